// File: doc/BRIEF.md
# Expansion Bus Target Port

This block is the target side of a standard-timing cycle on a 32-bit expansion bus. It watches the cycle-start and command strobes, the address lines, the memory/I-O select, the direction line, the byte enables and the DMA address-enable line. When the address falls inside its configured window it claims the cycle by pulling a size-acknowledge line low. This is the 32-bit line or the 16-bit line, as a parameter selects. For an I/O window it can also pull a legacy 16-bit I/O line low.

The decoded target, byte enables and direction are captured at the clock edge that ends the start period. After that the address lines may change freely. During the command period the block holds the open-collector ready line low for a programmable number of wait states, from 0 to 7. On the edge that ends the command period it stores write data into a small bank of 32-bit registers, and only the enabled byte lanes are written. During a claimed read it drives the selected register onto the data bus while the command strobe is low.

All strobes are active low and are sampled on the rising clock edge. The start strobe is low for exactly one clock. The command strobe then stays low until the first edge at which the block is not pulling ready low.

Top module: `exp_bus_slave`

## Requirements
- R1: On a window hit with the start strobe low, the size acknowledge is asserted (low): `ack32_n` when `WIDE32`=1, `ack16_n` when `WIDE32`=0. The other acknowledge stays high, and the asserted one is held through the whole command period.
- R2: An address outside the window `BASE_ADDR` .. `BASE_ADDR + 4*NUM_REGS - 1`, or a cycle on the other space (`mem_io`=1 for memory, 0 for I/O), is not claimed. Such a cycle asserts no acknowledge, never pulls ready low and never changes a register.
- R3: An I/O window ignores every cycle that has `aen`=1. No acknowledge is asserted and no register changes. A memory window decodes regardless of `aen`.
- R4: When `LEGACY_IO16`=1 and the window is I/O, `io16_n` is low exactly while the size acknowledge is low. Otherwise it stays high.
- R5: Register index, byte enables (`be_n`) and direction (`wr_rd`, 1=write) are taken on the clock edge where the start strobe is low. Changes to `la`, `be_n`, `mem_io` or `wr_rd` during the command period have no effect.
- R6: For a claimed cycle with `wait_cnt`=W sampled at the end of the start period, `rdy_pull` is high for exactly the first W clocks of the command period and then falls.
- R7: With W=0, `rdy_pull` never goes high. Ready is never pulled for an unclaimed cycle or outside the command period.
- R8: A claimed write stores `wr_data` on the final command edge. Byte lane i (`wr_data[8i+7:8i]`) is written only when `be_n[i]`=0.
- R9: `rd_oe` is high, and `rd_data` carries the selected register, only while `cmd_n` is low in a claimed read. Otherwise `rd_oe`=0 and `rd_data`=0.
- R10: The register is selected by address bits `la[2 +: log2(NUM_REGS)]`.
- R11: After reset all registers read 0, and with the start strobe high all acknowledge lines are high, with `rdy_pull`=0 and `rd_oe`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_n | input | 1 | Cycle start strobe, low for one clock |
| cmd_n | input | 1 | Command strobe, low during the command period |
| la | input | 32 | Address lines |
| mem_io | input | 1 | 1 = memory cycle, 0 = I/O cycle |
| wr_rd | input | 1 | 1 = write, 0 = read |
| be_n | input | 4 | Byte enables, active low |
| aen | input | 1 | DMA address enable, 1 = address belongs to DMA |
| wr_data | input | 32 | Write data from the master |
| wait_cnt | input | WAIT_W | Wait states to insert |
| ack32_n | output | 1 | 32-bit size acknowledge, active low |
| ack16_n | output | 1 | 16-bit size acknowledge, active low |
| io16_n | output | 1 | Legacy 16-bit I/O indicator, active low |
| rdy_pull | output | 1 | 1 = pull the ready line low |
| rd_oe | output | 1 | Read data output enable |
| rd_data | output | 32 | Read data |

## Verification
A claim flag stuck high or cleared one edge early shows at the ports at once. An acknowledge is then still low after the command strobe rises, or ready is released while the command strobe is still low, and either is seen on the very next clock. A wait counter loaded with the wrong value or decremented off by one changes how many clocks ready stays low, so the wait count reported for that cycle is wrong. A register or latched index corrupted by a later address change stays hidden until the next read of that register, which then returns data that differs from the byte-merged model. The bench therefore reads back after every write.

// File: rtl/bsl_pkg.sv
package bsl_pkg;

  typedef struct packed {
    logic ack32_n;
    logic ack16_n;
    logic io16_n;
  } claim_lines_t;

  function automatic logic win_hit(input logic [31:0] addr,
                                   input logic [31:0] base,
                                   input int unsigned low_bits);
    logic [31:0] diff;
    diff = (addr ^ base) >> low_bits;
    return diff == 32'd0;
  endfunction

  function automatic claim_lines_t claim_lines(input logic ack,
                                               input bit wide32,
                                               input bit legacy,
                                               input bit is_mem);
    claim_lines_t c;
    c.ack32_n = !(ack && wide32);
    c.ack16_n = !(ack && !wide32);
    c.io16_n  = !(ack && legacy && !is_mem);
    return c;
  endfunction

endpackage

// File: rtl/bsl_decode.sv
module bsl_decode #(
  parameter logic [31:0] BASE_ADDR = 32'h0000_0300,
  parameter int unsigned WIN_BITS  = 4,
  parameter bit          IS_MEM    = 1'b0
) (
  input  logic [31:0] la,
  input  logic        mem_io,
  input  logic        aen,
  output logic        hit
);
  import bsl_pkg::*;

  logic in_win;
  logic space_ok;

  assign in_win = win_hit(la, BASE_ADDR, WIN_BITS);

  generate
    if (IS_MEM) begin : g_mem
      logic unused_aen;
      assign unused_aen = aen;
      assign space_ok   = mem_io;
    end else begin : g_io
      assign space_ok = !mem_io && !aen;
    end
  endgenerate

  assign hit = in_win && space_ok;
endmodule

// File: rtl/bsl_waitgen.sv
module bsl_waitgen #(
  parameter int unsigned WAIT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WAIT_W-1:0] load_val,
  input  logic              run,
  output logic              busy
);
  logic [WAIT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (load)            cnt_q <= load_val;
    else if (run && busy)     cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != '0);
endmodule

// File: rtl/bsl_regfile.sv
module bsl_regfile #(
  parameter int unsigned NUM_REGS = 4,
  parameter int unsigned IDXW     = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [IDXW-1:0] idx,
  input  logic [3:0]      be_n,
  input  logic [31:0]     wdata,
  output logic [31:0]     rdata
);
  logic [NUM_REGS*32-1:0] flat;

  generate
    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
      for (genvar b = 0; b < 4; b++) begin : g_lane
        logic [7:0] lane_q;
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)
            lane_q <= '0;
          else if (wr_en && (idx == IDXW'(r)) && !be_n[b])
            lane_q <= wdata[b*8 +: 8];
        end
        assign flat[(r*4+b)*8 +: 8] = lane_q;
      end
    end
  endgenerate

  assign rdata = flat[idx*32 +: 32];
endmodule

// File: rtl/exp_bus_slave.sv
module exp_bus_slave #(
  parameter logic [31:0] BASE_ADDR   = 32'h0000_0300,
  parameter int unsigned NUM_REGS    = 4,
  parameter bit          IS_MEM      = 1'b0,
  parameter bit          WIDE32      = 1'b1,
  parameter bit          LEGACY_IO16 = 1'b1,
  parameter int unsigned WAIT_W      = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_n,
  input  logic              cmd_n,
  input  logic [31:0]       la,
  input  logic              mem_io,
  input  logic              wr_rd,
  input  logic [3:0]        be_n,
  input  logic              aen,
  input  logic [31:0]       wr_data,
  input  logic [WAIT_W-1:0] wait_cnt,
  output logic              ack32_n,
  output logic              ack16_n,
  output logic              io16_n,
  output logic              rdy_pull,
  output logic              rd_oe,
  output logic [31:0]       rd_data
);
  import bsl_pkg::*;

  localparam int unsigned IDXW     = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam int unsigned WIN_BITS = IDXW + 2;

  logic            hit;
  logic            claim_q;
  logic [IDXW-1:0] idx_q;
  logic [3:0]      be_q;
  logic            wr_q;
  logic            busy;
  logic [31:0]     reg_rd;
  claim_lines_t    lines;

  // named internal events
  logic evt_latch;
  logic evt_cmd;
  logic evt_final;
  logic ack;

  bsl_decode #(
    .BASE_ADDR (BASE_ADDR),
    .WIN_BITS  (WIN_BITS),
    .IS_MEM    (IS_MEM)
  ) u_dec (
    .la     (la),
    .mem_io (mem_io),
    .aen    (aen),
    .hit    (hit)
  );

  assign evt_latch = !start_n;
  assign evt_cmd   = claim_q && !cmd_n;
  assign evt_final = evt_cmd && !busy;
  assign ack       = (evt_latch && hit) || claim_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      claim_q <= 1'b0;
      idx_q   <= '0;
      be_q    <= 4'hF;
      wr_q    <= 1'b0;
    end else if (evt_latch) begin
      claim_q <= hit;
      idx_q   <= la[2 +: IDXW];
      be_q    <= be_n;
      wr_q    <= wr_rd;
    end else if (evt_final) begin
      claim_q <= 1'b0;
    end
  end

  bsl_waitgen #(.WAIT_W(WAIT_W)) u_wait (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (evt_latch && hit),
    .load_val (wait_cnt),
    .run      (evt_cmd),
    .busy     (busy)
  );

  bsl_regfile #(.NUM_REGS(NUM_REGS), .IDXW(IDXW)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (evt_final && wr_q),
    .idx   (idx_q),
    .be_n  (be_q),
    .wdata (wr_data),
    .rdata (reg_rd)
  );

  assign lines    = claim_lines(ack, WIDE32, LEGACY_IO16, IS_MEM);
  assign ack32_n  = lines.ack32_n;
  assign ack16_n  = lines.ack16_n;
  assign io16_n   = lines.io16_n;
  assign rdy_pull = evt_cmd && busy;
  assign rd_oe    = evt_cmd && !wr_q;
  assign rd_data  = rd_oe ? reg_rd : 32'd0;
endmodule

// File: rtl/bsl_check.sv
module bsl_check (
  input logic clk,
  input logic rst_n,
  input logic start_n,
  input logic cmd_n,
  input logic aen,
  input logic mem_io,
  input logic ack32_n,
  input logic ack16_n,
  input logic io16_n,
  input logic rdy_pull,
  input logic rd_oe,
  input logic claim_q,
  input logic evt_final
);
  logic any_ack;
  assign any_ack = !ack32_n || !ack16_n;

  p_one_width_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ack32_n && !ack16_n));

  p_aen_blocks_io_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_n && aen && !mem_io && !claim_q) |-> !any_ack);

  p_io16_with_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !io16_n |-> any_ack);

  p_rdy_in_claim_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_pull |-> (!cmd_n && any_ack));

  p_final_releases_r6: assert property (@(posedge clk) disable iff (!rst_n)
    evt_final |-> !rdy_pull);

  p_claim_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_final && start_n) |=> !claim_q);

  p_oe_in_cmd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_oe |-> (!cmd_n && any_ack));
endmodule

bind exp_bus_slave bsl_check u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_n   (start_n),
  .cmd_n     (cmd_n),
  .aen       (aen),
  .mem_io    (mem_io),
  .ack32_n   (ack32_n),
  .ack16_n   (ack16_n),
  .io16_n    (io16_n),
  .rdy_pull  (rdy_pull),
  .rd_oe     (rd_oe),
  .claim_q   (claim_q),
  .evt_final (evt_final)
);

// File: tb/sim_exp_bus_slave.sv
module sim_exp_bus_slave;
  localparam logic [31:0] BASE0 = 32'h0000_0300;  // I/O, 32-bit, legacy line
  localparam logic [31:0] BASE1 = 32'h000C_8000;  // memory, 16-bit

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_n = 1'b1, cmd_n = 1'b1, mem_io = 1'b0, wr_rd = 1'b0, aen = 1'b0;
  logic [31:0] la = '0, wr_data = '0;
  logic [3:0]  be_n = 4'hF;
  logic [2:0]  wait_cnt = '0;

  logic a32_0, a16_0, io_0, rp_0, oe_0;
  logic a32_1, a16_1, io_1, rp_1, oe_1;
  logic [31:0] rd_0, rd_1;

  int n_tests = 0, n_fail = 0;
  logic [31:0] model0 [4];
  logic [31:0] model1 [4];

  // sampled per cycle
  logic s_a32_0, s_a16_0, s_io_0, s_a32_1, s_a16_1, s_io_1, held_ok, post_ok, oe_ok;
  int   s_waits;
  logic [31:0] s_rd;

  always #4 clk = ~clk;

  exp_bus_slave #(.BASE_ADDR(BASE0), .IS_MEM(1'b0), .WIDE32(1'b1), .LEGACY_IO16(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .start_n(start_n), .cmd_n(cmd_n), .la(la), .mem_io(mem_io),
    .wr_rd(wr_rd), .be_n(be_n), .aen(aen), .wr_data(wr_data), .wait_cnt(wait_cnt),
    .ack32_n(a32_0), .ack16_n(a16_0), .io16_n(io_0), .rdy_pull(rp_0), .rd_oe(oe_0), .rd_data(rd_0));

  exp_bus_slave #(.BASE_ADDR(BASE1), .IS_MEM(1'b1), .WIDE32(1'b0), .LEGACY_IO16(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .start_n(start_n), .cmd_n(cmd_n), .la(la), .mem_io(mem_io),
    .wr_rd(wr_rd), .be_n(be_n), .aen(aen), .wr_data(wr_data), .wait_cnt(wait_cnt),
    .ack32_n(a32_1), .ack16_n(a16_1), .io16_n(io_1), .rdy_pull(rp_1), .rd_oe(oe_1), .rd_data(rd_1));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw, input logic [3:0] ben);
    logic [31:0] r;
    for (int i = 0; i < 4; i++) r[i*8 +: 8] = ben[i] ? old[i*8 +: 8] : nw[i*8 +: 8];
    return r;
  endfunction

  function automatic bit hit0(input logic [31:0] a, input logic m, input logic ae);
    return (a[31:4] == BASE0[31:4]) && !m && !ae;
  endfunction

  function automatic bit hit1(input logic [31:0] a, input logic m);
    return (a[31:4] == BASE1[31:4]) && m;
  endfunction

  task automatic run_cycle(input logic [31:0] a, input logic m, input logic w, input logic [3:0] ben,
                           input logic [31:0] wd, input logic [2:0] ws, input logic ae);
    @(negedge clk);
    la = a; mem_io = m; wr_rd = w; be_n = ben; wr_data = wd; wait_cnt = ws; aen = ae; start_n = 1'b0;
    #1;
    s_a32_0 = a32_0; s_a16_0 = a16_0; s_io_0 = io_0;
    s_a32_1 = a32_1; s_a16_1 = a16_1; s_io_1 = io_1;
    @(negedge clk);
    start_n = 1'b0; start_n = 1'b1; cmd_n = 1'b0;
    la = ~a; be_n = ~ben; mem_io = ~m; wr_rd = ~w; wait_cnt = ~ws; // R5 disturbances
    s_waits = 0; held_ok = 1'b1; oe_ok = 1'b1;
    for (int g = 0; g < 12; g++) begin
      #1;
      if (!(rp_0 || rp_1)) break;
      s_waits++;
      if ((a32_0 != s_a32_0) || (a16_1 != s_a16_1)) held_ok = 1'b0;
      @(negedge clk);
    end
    if ((a32_0 != s_a32_0) || (a16_1 != s_a16_1)) held_ok = 1'b0;
    s_rd = oe_0 ? rd_0 : (oe_1 ? rd_1 : 32'hDEAD_0000);
    if ((oe_0 || oe_1) == w) oe_ok = 1'b0;
    @(negedge clk);
    cmd_n = 1'b1;
    #1;
    post_ok = a32_0 && a16_0 && io_0 && a32_1 && a16_1 && io_1 && !rp_0 && !rp_1 &&
              !oe_0 && !oe_1 && (rd_0 == 0) && (rd_1 == 0);
  endtask

  // full cycle with expectation checks
  task automatic bus_op(input logic [31:0] a, input logic m, input logic w, input logic [3:0] ben,
                        input logic [31:0] wd, input logic [2:0] ws, input logic ae);
    bit h0, h1;
    int idx;
    logic [31:0] exp_rd;
    h0 = hit0(a, m, ae);
    h1 = hit1(a, m);
    idx = int'(a[3:2]);
    exp_rd = h0 ? model0[idx] : (h1 ? model1[idx] : 32'hDEAD_0000);
    run_cycle(a, m, w, ben, wd, ws, ae);
    chk((s_a32_0 == !h0) && s_a16_0 && s_a32_1, "R1/R2/R3 u0 32-bit claim", {31'd0, s_a32_0}, {31'd0, !h0});
    chk((s_a16_1 == !h1) && s_io_1, "R1/R2 u1 16-bit claim", {31'd0, s_a16_1}, {31'd0, !h1});
    chk(s_io_0 == !h0, "R4 legacy io line", {31'd0, s_io_0}, {31'd0, !h0});
    chk(s_waits == ((h0 || h1) ? int'(ws) : 0), "R6/R7 wait count", s_waits, (h0 || h1) ? ws : 0);
    chk(held_ok && post_ok, "R1/R9 hold and release", {30'd0, held_ok, post_ok}, 32'd3);
    if (h0 || h1) begin
      chk(oe_ok, "R9 read enable only on read", {31'd0, oe_ok}, 32'd1);
      if (!w) chk(s_rd == exp_rd, "R9/R10 read data", s_rd, exp_rd);
    end
    if (w && h0) model0[idx] = merge(model0[idx], wd, ben);  // R8
    if (w && h1) model1[idx] = merge(model1[idx], wd, ben);
  endtask

  task automatic verify_all;
    for (int i = 0; i < 4; i++) begin
      bus_op(BASE0 + 32'(i*4), 1'b0, 1'b0, 4'h0, 0, 3'd0, 1'b0);
      bus_op(BASE1 + 32'(i*4), 1'b1, 1'b0, 4'h0, 0, 3'd1, 1'b1);
    end
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    n_tests++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 4; i++) begin model0[i] = '0; model1[i] = '0; end
    repeat (3) @(negedge clk);
    #1;
    // R11: reset state
    chk(a32_0 && a16_0 && io_0 && a32_1 && a16_1 && io_1 && !rp_0 && !rp_1 && !oe_0 && !oe_1,
        "R11 outputs released in reset", {26'd0, a32_0, a16_0, io_0, rp_0, oe_0, oe_1}, 32'h38);
    @(negedge clk); rst_n = 1'b1;
    verify_all();  // R11 registers read zero

    // R8: full and partial byte writes, R10 index
    bus_op(BASE0 + 4, 1'b0, 1'b1, 4'h0, 32'h1122_3344, 3'd0, 1'b0);
    bus_op(BASE0 + 4, 1'b0, 1'b1, 4'b1010, 32'hAABB_CCDD, 3'd2, 1'b0);
    bus_op(BASE0 + 12, 1'b0, 1'b1, 4'b0111, 32'h9900_0000, 3'd7, 1'b0);  // R6 max waits
    verify_all();
    // R3: DMA address ignored by I/O window, accepted by memory window
    bus_op(BASE0 + 4, 1'b0, 1'b1, 4'h0, 32'hFFFF_FFFF, 3'd3, 1'b1);
    bus_op(BASE1 + 8, 1'b1, 1'b1, 4'b1100, 32'h0000_5A5A, 3'd4, 1'b1);
    // R2: wrong space and out-of-window
    bus_op(BASE0 + 8, 1'b1, 1'b1, 4'h0, 32'h7777_7777, 3'd5, 1'b0);
    bus_op(BASE1 + 16, 1'b1, 1'b1, 4'h0, 32'h7777_7777, 3'd5, 1'b0);
    bus_op(BASE0 - 4, 1'b0, 1'b1, 4'h0, 32'h7777_7777, 3'd5, 1'b0);
    verify_all();

    // random mix
    for (int n = 0; n < 300; n++) begin
      logic [31:0] a;
      logic m;
      int sel;
      sel = int'($urandom % 5);
      m = sel[0];
      case (sel)
        0, 1: a = (m ? BASE1 : BASE0) + 32'($urandom % 16);
        2:    a = BASE1 + 32'($urandom % 16);
        3:    a = BASE0 + 32'($urandom % 16);
        default: a = $urandom;
      endcase
      bus_op(a, m, 1'($urandom), 4'($urandom), $urandom, 3'($urandom), ($urandom % 4) == 0);
    end
    verify_all();

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule